// File: doc/BRIEF.md
# Shared Timer and Watchdog Prescaler

This block holds an 8-bit timer, a watchdog timeout counter and a single binary prescaler. Only one of the two counters can use the prescaler at a time. The timer takes its events either from the core clock, one per cycle, or from edges on an external pin. The pin is synchronized, and a select input picks whether rising or falling edges count. The watchdog takes its events from a fixed base divider of the core clock. Whichever counter owns the prescaler sees one event for every 2^k source events. The other counter runs unscaled.

The block is built so that moving the prescaler, changing the edge polarity or changing the timer source never creates an event. A false event could advance the watchdog and raise a reset request that nothing caused. In the cycle where any of these selects changes, every count input is held off. When the owner of the prescaler changes, the prescaler also starts again from zero. Software kicks the watchdog with a clear strobe. The strobe restarts the watchdog count, its base divider and the prescaler together.

Top module: `shared_prescale_timer_wdt`

## Requirements
- R1: After reset, `tmr_val`, `tmr_ovf` and `wdt_rst` are 0. With all select inputs tied low, the block is in its power-up arrangement: `ps_to_tmr`=0 gives the prescaler to the watchdog, and `src_int`=0 takes timer events from the external pin. A quiet pin then leaves the timer at 0, and with `rate`=1 the first `wdt_rst` follows 2*BASE_DIV*2^WDT_W cycles after reset release.
- R2: With `src_int`=1 and `ps_to_tmr`=0, `tmr_val` rises by exactly 1 every clock. On the wrap from all ones to 0, `tmr_ovf` is high for one cycle, and the timer then reads 0.
- R3: With `src_int`=0, the pin passes through a SYNC_STAGES-flop synchronizer. `edge_fall`=0 counts rising edges and `edge_fall`=1 counts falling edges, one timer increment each when the prescaler is with the watchdog.
- R4: With `ps_to_tmr`=1, the timer advances once for every 2^k source events, where k is `rate` clamped to PS_W. The count starts from the last prescaler clear.
- R5: With `ps_to_tmr`=0 and rate k, `wdt_rst` rises exactly BASE_DIV*2^(k+WDT_W) clock edges after the edge that samples `wdt_clr`.
- R6: With `ps_to_tmr`=1, the watchdog is unscaled. `wdt_rst` rises BASE_DIV*2^WDT_W edges after a clear, whatever the rate.
- R7: `wdt_rst` is a single-cycle pulse raised on the watchdog count rollover.
- R8: `wdt_clr` resets the watchdog count, its base divider and the prescaler. Kicking it more often than the timeout keeps `wdt_rst` low.
- R9: In the cycle after any change of `ps_to_tmr`, `src_int` or `edge_fall`, no counter advances. A change of these selects while the pin is static never advances the timer or the watchdog.
- R10: Any change of `ps_to_tmr` clears the prescaler, so the new owner starts a full 2^k period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ps_to_tmr | input | 1 | 1: prescaler drives the timer; 0: prescaler drives the watchdog |
| src_int | input | 1 | 1: timer counts core clocks; 0: timer counts pin edges |
| edge_fall | input | 1 | 1: falling pin edges count; 0: rising pin edges count |
| rate | input | RATE_W | Prescale exponent k, divide by 2^k, clamped to PS_W |
| ext_pin | input | 1 | Asynchronous external event pin |
| wdt_clr | input | 1 | Watchdog kick strobe |
| tmr_val | output | TMR_W | Timer value |
| tmr_ovf | output | 1 | One-cycle timer wrap flag |
| wdt_rst | output | 1 | One-cycle watchdog reset request |

## Verification
On every cycle the assertions check four things: the timer only steps by one, an overflow leaves the timer at zero, the reset request is a single-cycle pulse that cannot follow a kick, and the counters hold in the cycle after a select change. Only the bench scenarios can show the exact timeout periods for each prescale rate. The same goes for the timer division per rate, the choice between rising and falling edges, and the fresh prescaler period after a reassignment. Select toggling with a static pin, high or low, must leave both counters undisturbed; the bench shows this too.

// File: rtl/tw_pkg.sv
package tw_pkg;

   // Select inputs that steer events; any change masks one cycle of counting.
   typedef struct packed {
      logic to_tmr;
      logic src_int;
      logic fall;
   } tw_cfg_t;

endpackage

// File: rtl/tw_pin_edge.sv
module tw_pin_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic fall,
   input  logic hold,
   output logic edge_o
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic [SYNC_STAGES:0]   arm_q;
   logic                   prev_q;
   logic                   cur;
   logic                   rise_ev;
   logic                   fall_ev;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[i] <= 1'b0;
            else        sync_q[i] <= pin;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[i] <= 1'b0;
            else        sync_q[i] <= sync_q[i-1];
         end
      end
   end

   assign cur = sync_q[SYNC_STAGES-1];

   // The previous sample always tracks the current one, so an edge needs a real
   // pin change; the arm chain hides the fill of the synchronizer after reset.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         arm_q  <= '0;
      end else begin
         prev_q <= cur;
         arm_q  <= {arm_q[SYNC_STAGES-1:0], 1'b1};
      end
   end

   assign rise_ev = cur & ~prev_q;
   assign fall_ev = ~cur & prev_q;
   assign edge_o  = arm_q[SYNC_STAGES] & ~hold & (fall ? fall_ev : rise_ev);

endmodule

// File: rtl/tw_prescaler.sv
module tw_prescaler #(
   parameter int PS_W   = 8,
   parameter int RATE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              tick_in,
   input  logic [RATE_W-1:0] rate,
   output logic              tick_out
);

   logic [PS_W-1:0] cnt_q;
   logic [PS_W-1:0] mask;

   always_comb begin
      for (int i = 0; i < PS_W; i++) begin
         mask[i] = (i < int'(rate));
      end
   end

   // Output on the event that completes a 2^k group of inputs.
   assign tick_out = ~clr & tick_in & ((cnt_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clr)     cnt_q <= '0;
      else if (tick_in) cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/tw_timer.sv
module tw_timer #(
   parameter int TMR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   output logic [TMR_W-1:0] val,
   output logic             ovf
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val <= '0;
         ovf <= 1'b0;
      end else begin
         ovf <= tick & (&val);
         if (tick) val <= val + 1'b1;
      end
   end

endmodule

// File: rtl/tw_wdt.sv
module tw_wdt #(
   parameter int WDT_W    = 8,
   parameter int BASE_DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic cnt_tick,
   output logic base_tick,
   output logic rst_req
);

   localparam int               BASE_W   = $clog2(BASE_DIV);
   localparam logic [BASE_W-1:0] DIV_LAST = BASE_W'(BASE_DIV - 1);

   logic [BASE_W-1:0] div_q;
   logic [WDT_W-1:0]  cnt_q;

   assign base_tick = ~clr & (div_q == DIV_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 div_q <= '0;
      else if (clr)               div_q <= '0;
      else if (div_q == DIV_LAST) div_q <= '0;
      else                        div_q <= div_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         rst_req <= 1'b0;
      end else if (clr) begin
         cnt_q   <= '0;
         rst_req <= 1'b0;
      end else begin
         rst_req <= cnt_tick & (&cnt_q);
         if (cnt_tick) cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/shared_prescale_timer_wdt.sv
module shared_prescale_timer_wdt
   import tw_pkg::*;
#(
   parameter int  TMR_W       = 8,
   parameter int  PS_W        = 8,
   parameter int  WDT_W       = 8,
   parameter int  BASE_DIV    = 16,
   parameter int  SYNC_STAGES = 2,
   localparam int RATE_W      = $clog2(PS_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ps_to_tmr,
   input  logic              src_int,
   input  logic              edge_fall,
   input  logic [RATE_W-1:0] rate,
   input  logic              ext_pin,
   input  logic              wdt_clr,
   output logic [TMR_W-1:0]  tmr_val,
   output logic              tmr_ovf,
   output logic              wdt_rst
);

   if (TMR_W < 2) begin : g_bad_tmr
      $error("TMR_W must be at least 2");
   end
   if (PS_W < 1) begin : g_bad_ps
      $error("PS_W must be at least 1");
   end
   if (WDT_W < 2) begin : g_bad_wdt
      $error("WDT_W must be at least 2");
   end
   if (BASE_DIV < 2) begin : g_bad_div
      $error("BASE_DIV must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   localparam logic [RATE_W-1:0] RATE_MAX = RATE_W'(PS_W);

   tw_cfg_t          cfg_now;
   tw_cfg_t          cfg_q;
   logic             cfg_valid_q;
   logic             cfg_chg;
   logic             asg_chg;
   logic [RATE_W-1:0] rate_c;
   logic             ext_edge;
   logic             src_tick;
   logic             base_tick;
   logic             ps_in;
   logic             ps_out;
   logic             ps_clr;
   logic             tmr_tick;
   logic             wdt_tick;

   assign cfg_now = '{to_tmr: ps_to_tmr, src_int: src_int, fall: edge_fall};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q       <= '0;
         cfg_valid_q <= 1'b0;
      end else begin
         cfg_q       <= cfg_now;
         cfg_valid_q <= 1'b1;
      end
   end

   // A select change masks all counting for one cycle; an owner change also
   // restarts the prescaler.
   assign cfg_chg = cfg_valid_q & (cfg_now != cfg_q);
   assign asg_chg = cfg_valid_q & (cfg_now.to_tmr != cfg_q.to_tmr);
   assign rate_c  = (rate > RATE_MAX) ? RATE_MAX : rate;

   tw_pin_edge #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin    (ext_pin),
      .fall   (edge_fall),
      .hold   (cfg_chg),
      .edge_o (ext_edge)
   );

   assign src_tick = src_int ? 1'b1 : ext_edge;
   assign ps_in    = ~cfg_chg & (ps_to_tmr ? src_tick : base_tick);
   assign ps_clr   = wdt_clr | asg_chg;

   tw_prescaler #(
      .PS_W   (PS_W),
      .RATE_W (RATE_W)
   ) u_ps (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (ps_clr),
      .tick_in  (ps_in),
      .rate     (rate_c),
      .tick_out (ps_out)
   );

   assign tmr_tick = ~cfg_chg & (ps_to_tmr ? ps_out : src_tick);
   assign wdt_tick = ~cfg_chg & (ps_to_tmr ? base_tick : ps_out);

   tw_timer #(
      .TMR_W (TMR_W)
   ) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tmr_tick),
      .val   (tmr_val),
      .ovf   (tmr_ovf)
   );

   tw_wdt #(
      .WDT_W    (WDT_W),
      .BASE_DIV (BASE_DIV)
   ) u_wdt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (wdt_clr),
      .cnt_tick  (wdt_tick),
      .base_tick (base_tick),
      .rst_req   (wdt_rst)
   );

endmodule

// File: rtl/shared_prescale_timer_wdt_chk.sv
module shared_prescale_timer_wdt_chk #(
   parameter int TMR_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ps_to_tmr,
   input logic             src_int,
   input logic             edge_fall,
   input logic             wdt_clr,
   input logic [TMR_W-1:0] tmr_val,
   input logic             tmr_ovf,
   input logic             wdt_rst
);

   logic [2:0] sel;
   assign sel = {ps_to_tmr, src_int, edge_fall};

   assert_tmr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_val != $past(tmr_val)) |-> (tmr_val == $past(tmr_val) + 1'b1));

   assert_ovf_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf |-> (tmr_val == '0));

   assert_rst_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst |=> !wdt_rst);

   assert_kick_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_clr |=> !wdt_rst);

   assert_sel_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel != $past(sel)) |=> $stable(tmr_val));

endmodule

bind shared_prescale_timer_wdt shared_prescale_timer_wdt_chk #(
   .TMR_W (TMR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ps_to_tmr (ps_to_tmr),
   .src_int   (src_int),
   .edge_fall (edge_fall),
   .wdt_clr   (wdt_clr),
   .tmr_val   (tmr_val),
   .tmr_ovf   (tmr_ovf),
   .wdt_rst   (wdt_rst)
);

// File: tb/shared_prescale_timer_wdt_tb.sv
module shared_prescale_timer_wdt_tb;

   localparam int TMR_W    = 8;
   localparam int PS_W     = 8;
   localparam int WDT_W    = 6;
   localparam int BASE_DIV = 2;
   localparam int RATE_W   = $clog2(PS_W + 1);
   localparam int TMOD     = 1 << TMR_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ps_to_tmr = 1'b0;
   logic              src_int = 1'b0;
   logic              edge_fall = 1'b0;
   logic [RATE_W-1:0] rate = RATE_W'(1);
   logic              ext_pin = 1'b0;
   logic              wdt_clr = 1'b0;
   logic [TMR_W-1:0]  tmr_val;
   logic              tmr_ovf;
   logic              wdt_rst;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   shared_prescale_timer_wdt #(
      .TMR_W       (TMR_W),
      .PS_W        (PS_W),
      .WDT_W       (WDT_W),
      .BASE_DIV    (BASE_DIV),
      .SYNC_STAGES (2)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ps_to_tmr (ps_to_tmr),
      .src_int   (src_int),
      .edge_fall (edge_fall),
      .rate      (rate),
      .ext_pin   (ext_pin),
      .wdt_clr   (wdt_clr),
      .tmr_val   (tmr_val),
      .tmr_ovf   (tmr_ovf),
      .wdt_rst   (wdt_rst)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic kick();
      wdt_clr = 1'b1;
      @(negedge clk);
      wdt_clr = 1'b0;
   endtask

   task automatic meas_wdt(input string req, input int exp);
      int n = 0;
      int hit = 0;
      kick();
      while (hit == 0 && n < exp + 16) begin
         @(negedge clk);
         n++;
         if (wdt_rst) hit = n;
      end
      check(req, hit, exp);
      @(negedge clk);
      check({req, " R7 pulse width"}, int'(wdt_rst), 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int t0;
      int n;
      int hit;
      int ovfs;
      int rst_seen;

      // R1: reset state and power-up arrangement (selects low, rate 1)
      wait_n(4);
      check("R1 tmr_val in reset", int'(tmr_val), 0);
      check("R1 tmr_ovf in reset", int'(tmr_ovf), 0);
      check("R1 wdt_rst in reset", int'(wdt_rst), 0);
      rst_n = 1'b1;
      n = 0;
      hit = 0;
      while (hit == 0 && n < 600) begin
         @(negedge clk);
         n++;
         if (wdt_rst) hit = n;
      end
      check("R1 first timeout via prescaler", hit, 2 * BASE_DIV * (1 << WDT_W));
      check("R1 quiet pin keeps timer", int'(tmr_val), 0);

      // R2: internal source, unscaled, with wraps
      src_int = 1'b1;
      wait_n(3);
      t0 = int'(tmr_val);
      ovfs = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (tmr_ovf) ovfs++;
      end
      check("R2 timer delta", int'(tmr_val), (t0 + 300) % TMOD);
      check("R2 overflow pulses", ovfs, (t0 + 300) / TMOD);

      // R5: watchdog timeout per prescale rate
      for (int k = 0; k <= PS_W; k++) begin
         rate = RATE_W'(k);
         wait_n(2);
         meas_wdt($sformatf("R5 timeout rate %0d", k), BASE_DIV * (1 << (k + WDT_W)));
      end

      // R4: prescaler on timer, internal source, sweep of rates
      ps_to_tmr = 1'b1;
      wait_n(3);
      for (int k = 0; k <= PS_W + 2; k++) begin
         rate = RATE_W'(k);
         wait_n(2);
         kick();
         t0 = int'(tmr_val);
         wait_n(600);
         check($sformatf("R4 timer rate %0d", k), int'(tmr_val),
               (t0 + (600 >> ((k > PS_W) ? PS_W : k))) % TMOD);
      end

      // R6: watchdog unscaled while the prescaler is with the timer
      rate = RATE_W'(5);
      wait_n(2);
      meas_wdt("R6 unscaled timeout", BASE_DIV * (1 << WDT_W));

      // R3: external edges, each polarity, prescaler with the watchdog
      ps_to_tmr = 1'b0;
      src_int = 1'b0;
      for (int e = 0; e < 2; e++) begin
         edge_fall = e[0];
         ext_pin = 1'b0;
         wait_n(6);
         t0 = int'(tmr_val);
         for (int p = 0; p < 5; p++) begin
            ext_pin = 1'b1;
            wait_n(4);
            if (p < 4) begin
               ext_pin = 1'b0;
               wait_n(4);
            end
         end
         wait_n(6);
         check($sformatf("R3 edges polarity %0d", e), int'(tmr_val),
               (t0 + ((e == 1) ? 4 : 5)) % TMOD);
      end

      // R4: external falling edges through the prescaler at 1:4
      edge_fall = 1'b1;
      ext_pin = 1'b1;
      rate = RATE_W'(2);
      wait_n(2);
      ps_to_tmr = 1'b1;
      wait_n(6);
      kick();
      t0 = int'(tmr_val);
      for (int p = 0; p < 12; p++) begin
         ext_pin = 1'b0;
         wait_n(4);
         ext_pin = 1'b1;
         wait_n(4);
      end
      wait_n(6);
      check("R4 external 1:4", int'(tmr_val), (t0 + 3) % TMOD);

      // R10: owner change restarts the prescaler
      ps_to_tmr = 1'b0;
      src_int = 1'b1;
      rate = RATE_W'(3);
      wait_n(3);
      kick();
      wait_n(5);
      ps_to_tmr = 1'b1;
      @(negedge clk);
      t0 = int'(tmr_val);
      wait_n(7);
      check("R10 no output before full period", int'(tmr_val), t0);
      wait_n(1);
      check("R10 output after full period", int'(tmr_val), (t0 + 1) % TMOD);

      // R9: select toggling with a static pin, both levels
      src_int = 1'b0;
      ps_to_tmr = 1'b0;
      rate = RATE_W'(0);
      for (int lvl = 0; lvl < 2; lvl++) begin
         ext_pin = lvl[0];
         wait_n(6);
         kick();
         t0 = int'(tmr_val);
         rst_seen = 0;
         for (int s = 0; s < 6; s++) begin
            edge_fall = ~edge_fall;
            wait_n(2);
            if (wdt_rst) rst_seen++;
            if (s == 2) ps_to_tmr = 1'b1;
            if (s == 4) ps_to_tmr = 1'b0;
            wait_n(1);
            if (wdt_rst) rst_seen++;
         end
         wait_n(6);
         check($sformatf("R9 timer still, pin %0d", lvl), int'(tmr_val), t0);
         check($sformatf("R9 no reset request, pin %0d", lvl), rst_seen, 0);
      end

      // R8: kicking faster than the timeout keeps the request low
      src_int = 1'b1;
      wait_n(3);
      rst_seen = 0;
      for (int r = 0; r < 6; r++) begin
         kick();
         for (int c = 0; c < BASE_DIV * (1 << WDT_W) - 10; c++) begin
            @(negedge clk);
            if (wdt_rst) rst_seen++;
         end
      end
      check("R8 regular kicks", rst_seen, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule